// File: doc/BRIEF.md
# Register Rename Unit with Rollback History

This unit renames one instruction per clock. It keeps one map table for each of four register classes. A source operand is translated through its class's table into a physical register. Alongside that register, a scoreboard bit says whether its value has been produced. A destination operand takes the lowest free physical register from its class's free list. The mapping it displaces is reported with the new one. The new register is marked not ready, and a record is appended at the young end of a history buffer. Each record carries the sequence number, a unified architectural index, the new register and the displaced register.

The history serves two purposes. A squash walks it from the youngest record down and rolls back every record younger than the squash sequence number. Each rollback restores the map entry and frees the register that had been allocated. A commit retires records from the old end up to the commit sequence number and frees the registers those records displaced. Writeback notifications set scoreboard bits. Both walks retire one record per cycle, and renaming stalls while a walk runs. Sequence numbers must rise from one accepted rename to the next.

Top module: `rename_unit`

## Requirements
- R1: After reset every class maps architectural register i to local physical register i, every scoreboard bit is ready, the history is empty and `busy` is low.
- R2: A source with class c (0 integer, 1 floating point, 2 condition code, 3 miscellaneous) reports physical register c*16 + map entry, together with that register's scoreboard bit.
- R3: A source naming the same architectural register as the same instruction's destination reports the mapping as it was before that destination is renamed.
- R4: A destination receives the lowest-numbered free register of its class, and the mapping it displaces is reported in `dstPrevPhys`. From the next cycle, sources see the new register, and it reads not ready until a writeback names it.
- R5: A writeback sets the ready bit of the register it names, and a source lookup of that register in the same cycle already reports it as ready.
- R6: `dstUniArch` is the class-relative index plus a base: 0 for integer, 8 for floating point, 16 for condition code and 20 for miscellaneous.
- R7: Integer and floating-point classes have 8 registers, and the other two classes have 4. An operand index at or beyond its class's count raises `renError`, and the instruction changes no state.
- R8: When the destination's class has no free register, `renStall` is raised and nothing is renamed.
- R9: A squash with sequence S raises `busy` from the next cycle. It then removes, youngest first, every record with sequence greater than S, restores each map entry and frees each new register.
- R10: A commit with sequence S raises `busy` and removes, oldest first, every record with sequence at or below S, freeing each displaced register.
- R11: While the history holds 16 records, a rename with a destination stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| renValid | input | 1 | an instruction is presented for renaming |
| renSeq | input | 16 | sequence number of the instruction |
| src0Valid | input | 1 | first source is used |
| src0Class | input | 2 | class of first source |
| src0Idx | input | 3 | class-relative index of first source |
| src1Valid | input | 1 | second source is used |
| src1Class | input | 2 | class of second source |
| src1Idx | input | 3 | class-relative index of second source |
| dstValid | input | 1 | destination is used |
| dstClass | input | 2 | class of destination |
| dstIdx | input | 3 | class-relative index of destination |
| wbValid | input | 1 | writeback notification |
| wbPhys | input | 6 | physical register written back |
| squashValid | input | 1 | squash request |
| squashSeq | input | 16 | records younger than this are rolled back |
| commitValid | input | 1 | commit request |
| commitSeq | input | 16 | records at or older than this are retired |
| renDone | output | 1 | the presented instruction was renamed this cycle |
| renStall | output | 1 | the presented instruction must be held |
| renError | output | 1 | an operand index is out of range |
| busy | output | 1 | a squash or commit walk is in progress |
| src0Phys | output | 6 | physical register of first source |
| src0Ready | output | 1 | first source value is available |
| src1Phys | output | 6 | physical register of second source |
| src1Ready | output | 1 | second source value is available |
| dstPhys | output | 6 | newly assigned destination register |
| dstPrevPhys | output | 6 | register previously mapped to the destination |
| dstUniArch | output | 5 | unified architectural index of the destination |

## Verification
The bench aims at the same-instruction source/destination overlap. A design that updated the table before the lookup would hand the source its own, not-yet-produced register. It also drives a writeback in the very cycle a source reads that register. Without the bypass, the operand would be reported as waiting forever. Squashes and commits are checked through later lookups and allocations. Restoring in the wrong order would leave a stale mapping in place, and freeing the wrong register of a record would either leak registers or hand out a live one. A bench-side model tracks this. Exhausting both the integer free list and the history shows whether a design overwrites live state when it should stall.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int NUM_CLS      = 4;
  localparam int CLS_W        = 2;
  localparam int ARCH_W       = 3;
  localparam int ARCH_SLOTS   = 1 << ARCH_W;
  localparam int PHYS_PER_CLS = 16;
  localparam int PL_W         = $clog2(PHYS_PER_CLS);
  localparam int PREG_W       = CLS_W + PL_W;
  localparam int UNI_W        = 5;

  localparam logic [CLS_W-1:0] CLS_INT  = 2'd0;
  localparam logic [CLS_W-1:0] CLS_FP   = 2'd1;
  localparam logic [CLS_W-1:0] CLS_CC   = 2'd2;
  localparam logic [CLS_W-1:0] CLS_MISC = 2'd3;

  // number of architectural registers a class really has
  function automatic logic [ARCH_W:0] archLimit(input logic [CLS_W-1:0] c);
    case (c)
      CLS_INT, CLS_FP: return (ARCH_W+1)'(ARCH_SLOTS);
      default:         return (ARCH_W+1)'(ARCH_SLOTS / 2);
    endcase
  endfunction

  // offset of a class inside the unified architectural index space
  function automatic logic [UNI_W-1:0] uniBase(input logic [CLS_W-1:0] c);
    case (c)
      CLS_INT: return UNI_W'(0);
      CLS_FP:  return UNI_W'(ARCH_SLOTS);
      CLS_CC:  return UNI_W'(2 * ARCH_SLOTS);
      default: return UNI_W'(2 * ARCH_SLOTS + ARCH_SLOTS / 2);
    endcase
  endfunction

  typedef struct packed {
    logic doRename;
    logic doSquashPop;
    logic doCommitPop;
  } rn_strobe_t;
endpackage

// File: rtl/rn_ctrl.sv
module rn_ctrl
  import rn_pkg::*;
#(
  parameter int SEQ_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               renValid,
  input  logic               src0Valid,
  input  logic [CLS_W-1:0]   src0Class,
  input  logic [ARCH_W-1:0]  src0Idx,
  input  logic               src1Valid,
  input  logic [CLS_W-1:0]   src1Class,
  input  logic [ARCH_W-1:0]  src1Idx,
  input  logic               dstValid,
  input  logic [CLS_W-1:0]   dstClass,
  input  logic [ARCH_W-1:0]  dstIdx,
  input  logic               squashValid,
  input  logic [SEQ_W-1:0]   squashSeq,
  input  logic               commitValid,
  input  logic [SEQ_W-1:0]   commitSeq,
  input  logic [NUM_CLS-1:0] freeAvail,
  input  logic               histEmpty,
  input  logic               histFull,
  input  logic [SEQ_W-1:0]   youngSeq,
  input  logic [SEQ_W-1:0]   oldSeq,
  output rn_strobe_t         strobe,
  output logic               renDone,
  output logic               renStall,
  output logic               renError,
  output logic               busy
);
  typedef enum logic [1:0] {ST_IDLE, ST_SQUASH, ST_COMMIT} walk_t;

  walk_t            state, stateNext;
  logic [SEQ_W-1:0] tgtSeq;
  logic             rangeErr;
  logic             holdOff;

  always_comb begin
    rangeErr = 1'b0;
    if (src0Valid && ({1'b0, src0Idx} >= archLimit(src0Class))) rangeErr = 1'b1;
    if (src1Valid && ({1'b0, src1Idx} >= archLimit(src1Class))) rangeErr = 1'b1;
    if (dstValid  && ({1'b0, dstIdx}  >= archLimit(dstClass)))  rangeErr = 1'b1;
  end

  assign busy     = (state != ST_IDLE);
  assign holdOff  = busy || squashValid || commitValid ||
                    (dstValid && (!freeAvail[dstClass] || histFull));
  assign renError = renValid && rangeErr;
  assign renStall = renValid && holdOff;
  assign renDone  = renValid && !rangeErr && !holdOff;

  always_comb begin
    strobe.doRename    = renDone;
    strobe.doSquashPop = (state == ST_SQUASH) && !histEmpty && (youngSeq > tgtSeq);
    strobe.doCommitPop = (state == ST_COMMIT) && !histEmpty && (oldSeq <= tgtSeq);
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (squashValid)      stateNext = ST_SQUASH;
        else if (commitValid) stateNext = ST_COMMIT;
      end
      ST_SQUASH: if (!strobe.doSquashPop) stateNext = ST_IDLE;
      ST_COMMIT: if (!strobe.doCommitPop) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      tgtSeq <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) begin
        if (squashValid)      tgtSeq <= squashSeq;
        else if (commitValid) tgtSeq <= commitSeq;
      end
    end
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.doRename, strobe.doSquashPop, strobe.doCommitPop})); // R9

  AST_SQUASH_YOUNGEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doSquashPop |=> (histEmpty || youngSeq < $past(youngSeq))); // R9

  AST_COMMIT_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doCommitPop |=> (histEmpty || oldSeq > $past(oldSeq))); // R10
endmodule

// File: rtl/rn_datapath.sv
module rn_datapath
  import rn_pkg::*;
#(
  parameter int SEQ_W      = 16,
  parameter int HIST_DEPTH = 16   // power of two: pointers wrap naturally
) (
  input  logic               clk,
  input  logic               rst_n,
  input  rn_strobe_t         strobe,
  input  logic [SEQ_W-1:0]   renSeq,
  input  logic [CLS_W-1:0]   src0Class,
  input  logic [ARCH_W-1:0]  src0Idx,
  input  logic [CLS_W-1:0]   src1Class,
  input  logic [ARCH_W-1:0]  src1Idx,
  input  logic               dstValid,
  input  logic [CLS_W-1:0]   dstClass,
  input  logic [ARCH_W-1:0]  dstIdx,
  input  logic               wbValid,
  input  logic [PREG_W-1:0]  wbPhys,
  output logic [PREG_W-1:0]  src0Phys,
  output logic               src0Ready,
  output logic [PREG_W-1:0]  src1Phys,
  output logic               src1Ready,
  output logic [PREG_W-1:0]  dstPhys,
  output logic [PREG_W-1:0]  dstPrevPhys,
  output logic [UNI_W-1:0]   dstUniArch,
  output logic [NUM_CLS-1:0] freeAvail,
  output logic               histEmpty,
  output logic               histFull,
  output logic [SEQ_W-1:0]   youngSeq,
  output logic [SEQ_W-1:0]   oldSeq
);
  localparam int HP_W = $clog2(HIST_DEPTH);

  logic [PL_W-1:0]                          mapTbl [NUM_CLS][ARCH_SLOTS];
  logic [NUM_CLS-1:0][PHYS_PER_CLS-1:0]     freeMask;
  logic [NUM_CLS-1:0][PL_W-1:0]             allocLocal;
  logic [NUM_CLS*PHYS_PER_CLS-1:0]          sbReady;

  logic [SEQ_W-1:0] hSeq  [HIST_DEPTH];
  logic [CLS_W-1:0] hCls  [HIST_DEPTH];
  logic [UNI_W-1:0] hUni  [HIST_DEPTH];
  logic [PL_W-1:0]  hNew  [HIST_DEPTH];
  logic [PL_W-1:0]  hPrev [HIST_DEPTH];
  logic [HP_W-1:0]  headPtr, tailPtr, youngPtr;
  logic [HP_W:0]    histCount;

  logic             pushNow;
  logic [PL_W-1:0]  prevLocal;
  logic [UNI_W-1:0] sqRel;

  // lowest free register of each class
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_alloc
    always_comb begin
      allocLocal[c] = '0;
      for (int p = PHYS_PER_CLS - 1; p >= 0; p--)
        if (freeMask[c][p]) allocLocal[c] = PL_W'(p);
    end
    assign freeAvail[c] = |freeMask[c];
  end

  // lookups read the table before this cycle's update lands
  assign src0Phys    = {src0Class, mapTbl[src0Class][src0Idx]};
  assign src1Phys    = {src1Class, mapTbl[src1Class][src1Idx]};
  assign src0Ready   = sbReady[src0Phys] || (wbValid && wbPhys == src0Phys);
  assign src1Ready   = sbReady[src1Phys] || (wbValid && wbPhys == src1Phys);
  assign prevLocal   = mapTbl[dstClass][dstIdx];
  assign dstPhys     = {dstClass, allocLocal[dstClass]};
  assign dstPrevPhys = {dstClass, prevLocal};
  assign dstUniArch  = uniBase(dstClass) + UNI_W'(dstIdx);

  assign pushNow   = strobe.doRename && dstValid;
  assign youngPtr  = tailPtr - HP_W'(1);
  assign youngSeq  = hSeq[youngPtr];
  assign oldSeq    = hSeq[headPtr];
  assign histEmpty = (histCount == '0);
  assign histFull  = (histCount == (HP_W+1)'(HIST_DEPTH));
  assign sqRel     = hUni[youngPtr] - uniBase(hCls[youngPtr]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CLS; c++)
        for (int a = 0; a < ARCH_SLOTS; a++)
          mapTbl[c][a] <= PL_W'(a);
    end else if (pushNow) begin
      mapTbl[dstClass][dstIdx] <= allocLocal[dstClass];
    end else if (strobe.doSquashPop) begin
      mapTbl[hCls[youngPtr]][sqRel[ARCH_W-1:0]] <= hPrev[youngPtr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CLS; c++)
        for (int p = 0; p < PHYS_PER_CLS; p++)
          freeMask[c][p] <= (p >= int'(archLimit(CLS_W'(c))));
    end else begin
      if (pushNow)            freeMask[dstClass][allocLocal[dstClass]] <= 1'b0;
      if (strobe.doSquashPop) freeMask[hCls[youngPtr]][hNew[youngPtr]] <= 1'b1;
      if (strobe.doCommitPop) freeMask[hCls[headPtr]][hPrev[headPtr]]  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbReady <= '1;
    end else begin
      if (wbValid) sbReady[wbPhys]  <= 1'b1;
      if (pushNow) sbReady[dstPhys] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      histCount <= '0;
    end else begin
      if (pushNow) begin
        tailPtr   <= tailPtr + HP_W'(1);
        histCount <= histCount + (HP_W+1)'(1);
      end else if (strobe.doSquashPop) begin
        tailPtr   <= youngPtr;
        histCount <= histCount - (HP_W+1)'(1);
      end else if (strobe.doCommitPop) begin
        headPtr   <= headPtr + HP_W'(1);
        histCount <= histCount - (HP_W+1)'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pushNow) begin
      hSeq[tailPtr]  <= renSeq;
      hCls[tailPtr]  <= dstClass;
      hUni[tailPtr]  <= dstUniArch;
      hNew[tailPtr]  <= allocLocal[dstClass];
      hPrev[tailPtr] <= prevLocal;
    end
  end

  AST_ALLOC_HAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pushNow |-> freeAvail[dstClass]); // R8

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    pushNow |-> !histFull); // R11

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    histCount <= (HP_W+1)'(HIST_DEPTH)); // R11

  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doSquashPop || strobe.doCommitPop) |-> !histEmpty); // R9

  AST_NEW_REG_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pushNow |=> !sbReady[$past(dstPhys)]); // R4
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
#(
  parameter int SEQ_W      = 16,
  parameter int HIST_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              renValid,
  input  logic [SEQ_W-1:0]  renSeq,
  input  logic              src0Valid,
  input  logic [CLS_W-1:0]  src0Class,
  input  logic [ARCH_W-1:0] src0Idx,
  input  logic              src1Valid,
  input  logic [CLS_W-1:0]  src1Class,
  input  logic [ARCH_W-1:0] src1Idx,
  input  logic              dstValid,
  input  logic [CLS_W-1:0]  dstClass,
  input  logic [ARCH_W-1:0] dstIdx,
  input  logic              wbValid,
  input  logic [PREG_W-1:0] wbPhys,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  output logic              renDone,
  output logic              renStall,
  output logic              renError,
  output logic              busy,
  output logic [PREG_W-1:0] src0Phys,
  output logic              src0Ready,
  output logic [PREG_W-1:0] src1Phys,
  output logic              src1Ready,
  output logic [PREG_W-1:0] dstPhys,
  output logic [PREG_W-1:0] dstPrevPhys,
  output logic [UNI_W-1:0]  dstUniArch
);
  rn_strobe_t         strobe;
  logic [NUM_CLS-1:0] freeAvail;
  logic               histEmpty, histFull;
  logic [SEQ_W-1:0]   youngSeq, oldSeq;

  rn_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .renValid(renValid),
    .src0Valid(src0Valid), .src0Class(src0Class), .src0Idx(src0Idx),
    .src1Valid(src1Valid), .src1Class(src1Class), .src1Idx(src1Idx),
    .dstValid(dstValid), .dstClass(dstClass), .dstIdx(dstIdx),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .freeAvail(freeAvail), .histEmpty(histEmpty), .histFull(histFull),
    .youngSeq(youngSeq), .oldSeq(oldSeq), .strobe(strobe),
    .renDone(renDone), .renStall(renStall), .renError(renError), .busy(busy)
  );

  rn_datapath #(.SEQ_W(SEQ_W), .HIST_DEPTH(HIST_DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .renSeq(renSeq),
    .src0Class(src0Class), .src0Idx(src0Idx),
    .src1Class(src1Class), .src1Idx(src1Idx),
    .dstValid(dstValid), .dstClass(dstClass), .dstIdx(dstIdx),
    .wbValid(wbValid), .wbPhys(wbPhys),
    .src0Phys(src0Phys), .src0Ready(src0Ready),
    .src1Phys(src1Phys), .src1Ready(src1Ready),
    .dstPhys(dstPhys), .dstPrevPhys(dstPrevPhys), .dstUniArch(dstUniArch),
    .freeAvail(freeAvail), .histEmpty(histEmpty), .histFull(histFull),
    .youngSeq(youngSeq), .oldSeq(oldSeq)
  );
endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
  localparam int SEQ_W = 16;
  localparam int HDEP  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic renValid = 0, src0Valid = 0, src1Valid = 0, dstValid = 0;
  logic wbValid = 0, squashValid = 0, commitValid = 0;
  logic [SEQ_W-1:0] renSeq = '0, squashSeq = '0, commitSeq = '0;
  logic [1:0] src0Class = 0, src1Class = 0, dstClass = 0;
  logic [2:0] src0Idx = 0, src1Idx = 0, dstIdx = 0;
  logic [5:0] wbPhys = 0;
  logic renDone, renStall, renError, busy, src0Ready, src1Ready;
  logic [5:0] src0Phys, src1Phys, dstPhys, dstPrevPhys;
  logic [4:0] dstUniArch;

  always #5 clk = ~clk;

  rename_unit u_dut (
    .clk(clk), .rst_n(rst_n), .renValid(renValid), .renSeq(renSeq),
    .src0Valid(src0Valid), .src0Class(src0Class), .src0Idx(src0Idx),
    .src1Valid(src1Valid), .src1Class(src1Class), .src1Idx(src1Idx),
    .dstValid(dstValid), .dstClass(dstClass), .dstIdx(dstIdx),
    .wbValid(wbValid), .wbPhys(wbPhys),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .renDone(renDone), .renStall(renStall), .renError(renError), .busy(busy),
    .src0Phys(src0Phys), .src0Ready(src0Ready),
    .src1Phys(src1Phys), .src1Ready(src1Ready),
    .dstPhys(dstPhys), .dstPrevPhys(dstPrevPhys), .dstUniArch(dstUniArch)
  );

  typedef struct {
    string tag;
    bit stall, done, err, s0v, s1v, dv, s0r, s1r;
    int s0p, s1p, dp, dprev, duni;
  } exp_t;

  typedef struct { int seq, cls, arch, newL, prevL; } hrec_t;

  exp_t  expQ[$];
  hrec_t refHist[$];
  int    refMap [4][8];
  bit    refFree[4][16];
  bit    refSb  [64];
  int    checks = 0, fails = 0, seqCtr = 1;

  task automatic check(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic int archLim(int c); return (c < 2) ? 8 : 4; endfunction
  function automatic int baseOf(int c);
    case (c) 0: return 0; 1: return 8; 2: return 16; default: return 20; endcase
  endfunction
  function automatic int lowFree(int c);
    for (int p = 0; p < 16; p++) if (refFree[c][p]) return p;
    return -1;
  endfunction

  // driver: presents one instruction for one cycle, queues what must come out
  task automatic ren(string tag, bit s0v, int s0c, int s0i, bit s1v, int s1c, int s1i,
                     bit dv, int dc, int di, bit wbv = 0, int wbp = 0);
    exp_t e;
    int nl;
    renValid = 1; renSeq = SEQ_W'(seqCtr);
    src0Valid = s0v; src0Class = 2'(s0c); src0Idx = 3'(s0i);
    src1Valid = s1v; src1Class = 2'(s1c); src1Idx = 3'(s1i);
    dstValid = dv; dstClass = 2'(dc); dstIdx = 3'(di);
    wbValid = wbv; wbPhys = 6'(wbp);
    e.tag = tag; e.s0v = s0v; e.s1v = s1v; e.dv = dv;
    e.err = (s0v && s0i >= archLim(s0c)) || (s1v && s1i >= archLim(s1c)) ||
            (dv && di >= archLim(dc));
    e.stall = dv && (lowFree(dc) < 0 || refHist.size() >= HDEP);
    e.done = !e.err && !e.stall;
    e.s0p = s0c * 16 + refMap[s0c][s0i];
    e.s1p = s1c * 16 + refMap[s1c][s1i];
    e.s0r = refSb[e.s0p] || (wbv && wbp == e.s0p);
    e.s1r = refSb[e.s1p] || (wbv && wbp == e.s1p);
    nl = lowFree(dc);
    e.dp = dc * 16 + nl;
    e.dprev = dc * 16 + refMap[dc][di];
    e.duni = baseOf(dc) + di;
    expQ.push_back(e);
    if (wbv) refSb[wbp] = 1;
    if (e.done && dv) begin
      hrec_t h;
      h.seq = seqCtr; h.cls = dc; h.arch = di; h.newL = nl; h.prevL = refMap[dc][di];
      refHist.push_back(h);
      refMap[dc][di] = nl;
      refFree[dc][nl] = 0;
      refSb[dc * 16 + nl] = 0;
    end
    seqCtr++;
    @(posedge clk); #1;
    renValid = 0; wbValid = 0;
  endtask

  // monitor: compares the design's outputs against the queued expectations
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(renStall === e.stall, e.tag, "renStall", int'(renStall), int'(e.stall));
      check(renError === e.err,   e.tag, "renError", int'(renError), int'(e.err));
      check(renDone === e.done,   e.tag, "renDone",  int'(renDone),  int'(e.done));
      if (!e.err && e.s0v) begin
        check(int'(src0Phys) == e.s0p, e.tag, "src0Phys", int'(src0Phys), e.s0p);
        check(src0Ready === e.s0r, e.tag, "src0Ready", int'(src0Ready), int'(e.s0r));
      end
      if (!e.err && e.s1v) begin
        check(int'(src1Phys) == e.s1p, e.tag, "src1Phys", int'(src1Phys), e.s1p);
        check(src1Ready === e.s1r, e.tag, "src1Ready", int'(src1Ready), int'(e.s1r));
      end
      if (e.done && e.dv) begin
        check(int'(dstPhys) == e.dp, e.tag, "dstPhys", int'(dstPhys), e.dp);
        check(int'(dstPrevPhys) == e.dprev, e.tag, "dstPrevPhys", int'(dstPrevPhys), e.dprev);
        check(int'(dstUniArch) == e.duni, e.tag, "dstUniArch", int'(dstUniArch), e.duni);
      end
    end
  end

  task automatic walkDone(string tag);
    @(negedge clk);
    check(busy === 1'b1, tag, "busy during walk", int'(busy), 1);
    @(posedge clk); #1;
    for (int k = 0; k < 64 && busy; k++) begin @(posedge clk); #1; end
    check(busy === 1'b0, tag, "busy after walk", int'(busy), 0);
  endtask

  task automatic squash(int s);
    squashValid = 1; squashSeq = SEQ_W'(s);
    @(posedge clk); #1;
    squashValid = 0;
    while (refHist.size() > 0 && refHist[refHist.size()-1].seq > s) begin
      hrec_t h;
      h = refHist.pop_back();
      refMap[h.cls][h.arch] = h.prevL;
      refFree[h.cls][h.newL] = 1;
    end
    walkDone("R9");
  endtask

  task automatic commit(int s);
    commitValid = 1; commitSeq = SEQ_W'(s);
    @(posedge clk); #1;
    commitValid = 0;
    while (refHist.size() > 0 && refHist[0].seq <= s) begin
      hrec_t h;
      h = refHist.pop_front();
      refFree[h.cls][h.prevL] = 1;
    end
    walkDone("R10");
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int mark;
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < 8; a++) refMap[c][a] = a;
      for (int p = 0; p < 16; p++) refFree[c][p] = (p >= archLim(c));
    end
    for (int p = 0; p < 64; p++) refSb[p] = 1;

    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
    check(renStall === 1'b0 && renDone === 1'b0, "R1", "idle outputs", int'(renStall), 0);
    @(posedge clk); #1;

    ren("R1", 1, 0, 3, 1, 1, 5, 0, 0, 0);     // identity map, all ready
    ren("R3", 1, 0, 2, 0, 0, 0, 1, 0, 2);     // source sees old mapping of int r2
    ren("R4", 1, 0, 2, 0, 0, 0, 0, 0, 0);     // now new reg, not ready
    ren("R5", 1, 0, 2, 0, 0, 0, 0, 0, 0, 1, 8); // same-cycle writeback bypass
    ren("R5", 1, 0, 2, 0, 0, 0, 0, 0, 0);     // stays ready
    ren("R6", 0, 0, 0, 0, 0, 0, 1, 1, 3);
    ren("R6", 0, 0, 0, 0, 0, 0, 1, 2, 1);
    ren("R6", 0, 0, 0, 0, 0, 0, 1, 3, 2);
    ren("R2", 1, 1, 3, 1, 2, 1, 0, 0, 0);
    ren("R7", 1, 2, 5, 0, 0, 0, 1, 0, 1);     // cc index 5 out of range
    ren("R7", 0, 0, 0, 0, 0, 0, 1, 3, 6);     // misc index 6 out of range
    ren("R7", 1, 0, 1, 1, 3, 2, 0, 0, 0);     // nothing changed

    mark = seqCtr;
    ren("R9", 0, 0, 0, 0, 0, 0, 1, 0, 4);
    ren("R9", 1, 0, 4, 0, 0, 0, 1, 0, 4);
    ren("R9", 0, 0, 0, 0, 0, 0, 1, 1, 3);
    squash(mark - 1);
    ren("R9", 1, 0, 4, 1, 1, 3, 0, 0, 0);     // restored mappings
    squash(seqCtr);                            // nothing to roll back
    ren("R9", 0, 0, 0, 0, 0, 0, 1, 0, 5);     // reuses freed register

    mark = seqCtr;
    commit(mark - 2);                          // partial commit
    ren("R10", 0, 0, 0, 0, 0, 0, 1, 0, 6);
    commit(seqCtr);
    ren("R10", 0, 0, 0, 0, 0, 0, 1, 0, 7);     // displaced regs returned
    commit(seqCtr);

    for (int k = 0; k < 9; k++) ren("R8", 1, 0, 0, 0, 0, 0, 1, 0, 0);
    ren("R8", 1, 0, 0, 0, 0, 0, 0, 0, 0);     // mapping untouched by stall
    commit(seqCtr);

    for (int k = 0; k < 8; k++) ren("R11", 0, 0, 0, 0, 0, 0, 1, 0, k);
    for (int k = 0; k < 8; k++) ren("R11", 0, 0, 0, 0, 0, 0, 1, 1, k);
    ren("R11", 0, 0, 0, 0, 0, 0, 1, 2, 0);    // history full
    squash(0);
    ren("R9", 1, 0, 3, 1, 1, 3, 0, 0, 0);

    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule